// File: doc/BRIEF.md
# EDO DRAM Refresh and Power-Up Scheduler

This block sequences the refresh side of an asynchronous EDO DRAM controller. After reset it keeps every strobe inactive for a power-up pause measured in clock cycles. It then runs a wake-up burst of eight CAS-before-RAS refresh cycles. Only after the burst does it declare the memory ready. From then on it requests one refresh per row interval. Each refresh uses the device's internal row counter, so no row address is supplied. The interval is 31.25 µs in 4K-row mode or 62.5 µs in 2K-row mode, which spreads a full refresh over a 128 ms retention window.

A single host requester shares the bus with the refresh engine. The host is granted only while no refresh is owed and no refresh cycle is on the bus. A grant, once given, is never revoked while the host keeps requesting. Refresh ticks that arrive during a grant are kept as a backlog. If the backlog would go past a configured limit, the block flags the starvation, drops its ready indication and repeats the eight-cycle wake-up burst. It does this as soon as the host lets go of the bus.

During a refresh the block drives the four DRAM strobes directly. CAS# falls first and stays low for a set number of clocks before RAS# falls. RAS# then stays low for its active time. Both strobes return high together and remain high for a precharge time. WE# and OE# stay high throughout.

Top module: `edo_refresh_sched`

## Requirements
- R1: While reset is held, ras_n, cas_n, we_n and oe_n are 1, and init_done, host_grant, refresh_busy and rfsh_missed are 0.
- R2: After reset is released, ras_n and cas_n stay 1 for at least CLK_MHZ*PAUSE_US clock cycles. The first strobe falls no later than two cycles after that.
- R3: Between reset release and the rise of init_done, exactly 8 refresh cycles (falling edges of ras_n) are issued. host_grant never rises while init_done is 0.
- R4: Each refresh cycle is CAS-before-RAS. cas_n is 0 for exactly CSR_CYC cycles before ras_n falls, and ras_n stays 0 for exactly RAS_CYC cycles. ras_n and cas_n rise in the same cycle and then stay 1 together for at least PRE_CYC cycles. we_n and oe_n are 1 whenever ras_n or cas_n is 0.
- R5: With init_done at 1 and no host activity, successive falling edges of ras_n are spaced exactly CLK_MHZ*31.25 cycles apart when mode_4k is 1, and exactly CLK_MHZ*62.5 cycles apart when mode_4k is 0.
- R6: host_grant and refresh_busy are never 1 in the same cycle. While host_grant is 1 and host_req stays 1, host_grant stays 1 and no refresh cycle starts. host_grant falls in the cycle after host_req falls.
- R7: If a refresh tick fell due while the host held the bus, that refresh is issued before a new host request is granted.
- R8: If a refresh tick arrives while the backlog already equals MAX_BACKLOG, rfsh_missed pulses for one cycle and init_done falls in the same cycle. Once the host releases the bus, exactly 8 refresh cycles are issued before init_done returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_4k | input | 1 | 1 selects the 31.25 µs row interval, 0 selects 62.5 µs |
| host_req | input | 1 | Host asks for the DRAM bus |
| host_grant | output | 1 | Host owns the DRAM bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high by this block |
| oe_n | output | 1 | Output enable, active low, held high by this block |
| init_done | output | 1 | Power-up pause and wake-up burst complete |
| refresh_busy | output | 1 | A refresh cycle occupies the bus |
| rfsh_missed | output | 1 | One-cycle pulse when the refresh backlog overflows |

## Verification
The bench builds the block with CLK_MHZ=4, PAUSE_US=100, CSR_CYC=2, RAS_CYC=4, PRE_CYC=3 and MAX_BACKLOG=3. With these values the power-up pause lasts 400 cycles and the two row intervals are 125 and 250 cycles. This makes the pause, both wake-up bursts and several intervals in each mode short enough to measure cycle by cycle. A backlog limit of 3 lets a host that holds the bus for five 4K intervals trigger the starvation path. A shorter hold of one and a half intervals leaves exactly one refresh owed, which shows the refresh winning over the next request.

// File: rtl/edo_rfsh_pkg.sv
`timescale 1ns/1ps
package edo_rfsh_pkg;

    localparam int unsigned WAKE_CYCLES = 8;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WAKE,
        PH_RUN
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CAS_LEAD,
        SQ_RAS_ACT,
        SQ_PRECH
    } seq_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBES_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    // 128 ms spread over 4096 rows gives 31.25 us; over 2048 rows gives 62.5 us.
    function automatic int unsigned row_interval_cycles(int unsigned clk_mhz, logic four_k);
        return four_k ? (clk_mhz * 3125) / 100 : (clk_mhz * 3125) / 50;
    endfunction

    function automatic int unsigned cnt_w(int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/edo_cbr_seq.sv
`timescale 1ns/1ps
module edo_cbr_seq
    import edo_rfsh_pkg::*;
#(
    parameter int unsigned CSR_CYC = 2,
    parameter int unsigned RAS_CYC = 6,
    parameter int unsigned PRE_CYC = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output strobe_t strb,
    output logic    busy,
    output logic    done
);

    localparam int unsigned MAXC = max3(CSR_CYC, RAS_CYC, PRE_CYC);
    localparam int unsigned W    = cnt_w(MAXC);

    seq_e          st;
    logic [W-1:0]  cnt;
    logic          cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st  <= SQ_CAS_LEAD;
                        cnt <= W'(CSR_CYC - 1);
                    end
                end
                SQ_CAS_LEAD: begin
                    if (cnt_zero) begin
                        st  <= SQ_RAS_ACT;
                        cnt <= W'(RAS_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_RAS_ACT: begin
                    if (cnt_zero) begin
                        st  <= SQ_PRECH;
                        cnt <= W'(PRE_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_PRECH: begin
                    if (cnt_zero) begin
                        st <= SQ_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Strobes decode straight from the state register: CAS# leads RAS#,
    // both release together on entry to precharge, WE#/OE# stay high.
    always_comb begin
        strb       = STROBES_IDLE;
        strb.cas_n = !((st == SQ_CAS_LEAD) || (st == SQ_RAS_ACT));
        strb.ras_n = !(st == SQ_RAS_ACT);
    end

    assign busy = (st != SQ_IDLE);
    assign done = (st == SQ_PRECH) && cnt_zero;

endmodule

// File: rtl/edo_row_timer.sv
`timescale 1ns/1ps
module edo_row_timer
    import edo_rfsh_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned MAX_BACKLOG = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic mode_4k,
    input  logic served,
    output logic pending,
    output logic miss
);

    localparam int unsigned INTV4 = row_interval_cycles(CLK_MHZ, 1'b1);
    localparam int unsigned INTV2 = row_interval_cycles(CLK_MHZ, 1'b0);
    localparam int unsigned IW    = cnt_w(INTV2);
    localparam int unsigned BW    = cnt_w(MAX_BACKLOG);

    logic [IW-1:0] cnt;
    logic [IW-1:0] reload;
    logic [BW-1:0] backlog;
    logic          tick;
    logic          dec;

    assign reload = mode_4k ? IW'(INTV4 - 1) : IW'(INTV2 - 1);
    assign tick   = run && (cnt == '0);
    assign dec    = served && (backlog != '0);
    assign miss   = tick && (backlog == BW'(MAX_BACKLOG));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt     <= reload;
            backlog <= '0;
        end else begin
            cnt <= tick ? reload : cnt - 1'b1;
            if (miss) begin
                backlog <= '0;
            end else begin
                case ({tick, dec})
                    2'b10:   backlog <= backlog + 1'b1;
                    2'b01:   backlog <= backlog - 1'b1;
                    default: backlog <= backlog;
                endcase
            end
        end
    end

    assign pending = (backlog != '0);

endmodule

// File: rtl/edo_init_ctl.sv
`timescale 1ns/1ps
module edo_init_ctl
    import edo_rfsh_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned PAUSE_US = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   miss,
    input  logic   seq_busy,
    input  logic   granted,
    output phase_e phase,
    output logic   wake_start
);

    localparam int unsigned PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int unsigned PW        = cnt_w(PAUSE_CYC);
    localparam int unsigned LW        = cnt_w(WAKE_CYCLES);

    logic [PW-1:0] pcnt;
    logic [LW-1:0] left;

    assign wake_start = (phase == PH_WAKE) && (left != '0) && !seq_busy && !granted;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_PAUSE;
            pcnt  <= PW'(PAUSE_CYC - 1);
            left  <= LW'(WAKE_CYCLES);
        end else begin
            case (phase)
                PH_PAUSE: begin
                    if (pcnt == '0) phase <= PH_WAKE;
                    else            pcnt  <= pcnt - 1'b1;
                end
                PH_WAKE: begin
                    if (wake_start)                      left  <= left - 1'b1;
                    else if ((left == '0) && !seq_busy)  phase <= PH_RUN;
                end
                PH_RUN: begin
                    if (miss) begin
                        phase <= PH_WAKE;
                        left  <= LW'(WAKE_CYCLES);
                    end
                end
                default: phase <= PH_PAUSE;
            endcase
        end
    end

endmodule

// File: rtl/edo_bus_arb.sv
`timescale 1ns/1ps
module edo_bus_arb
    import edo_rfsh_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  logic   host_req,
    input  logic   pending,
    input  logic   seq_busy,
    input  logic   wake_start,
    output logic   granted,
    output logic   rfsh_start
);

    logic run_ph;
    assign run_ph = (phase == PH_RUN);

    // Owed refresh wins over a new request; an existing grant is kept.
    assign rfsh_start = wake_start || (run_ph && pending && !seq_busy && !granted);

    always_ff @(posedge clk) begin
        if (rst) granted <= 1'b0;
        else     granted <= host_req && (granted || (run_ph && !pending && !seq_busy));
    end

endmodule

// File: rtl/edo_refresh_sched.sv
`timescale 1ns/1ps
module edo_refresh_sched
    import edo_rfsh_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned PAUSE_US    = 100,
    parameter int unsigned CSR_CYC     = 2,
    parameter int unsigned RAS_CYC     = 6,
    parameter int unsigned PRE_CYC     = 4,
    parameter int unsigned MAX_BACKLOG = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_4k,
    input  logic host_req,
    output logic host_grant,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic oe_n,
    output logic init_done,
    output logic refresh_busy,
    output logic rfsh_missed
);

    phase_e  phase;
    strobe_t strb;
    logic    seq_busy, seq_done, rfsh_start, wake_start;
    logic    pending, miss, granted, missed_q;

    edo_init_ctl #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US)) init_i (
        .clk(clk), .rst(rst), .miss(miss), .seq_busy(seq_busy),
        .granted(granted), .phase(phase), .wake_start(wake_start)
    );

    edo_row_timer #(.CLK_MHZ(CLK_MHZ), .MAX_BACKLOG(MAX_BACKLOG)) timer_i (
        .clk(clk), .rst(rst), .run(phase == PH_RUN), .mode_4k(mode_4k),
        .served(seq_done), .pending(pending), .miss(miss)
    );

    edo_bus_arb arb_i (
        .clk(clk), .rst(rst), .phase(phase), .host_req(host_req),
        .pending(pending), .seq_busy(seq_busy), .wake_start(wake_start),
        .granted(granted), .rfsh_start(rfsh_start)
    );

    edo_cbr_seq #(.CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) seq_i (
        .clk(clk), .rst(rst), .start(rfsh_start),
        .strb(strb), .busy(seq_busy), .done(seq_done)
    );

    always_ff @(posedge clk) begin
        if (rst) missed_q <= 1'b0;
        else     missed_q <= miss;
    end

    assign host_grant   = granted;
    assign ras_n        = strb.ras_n;
    assign cas_n        = strb.cas_n;
    assign we_n         = strb.we_n;
    assign oe_n         = strb.oe_n;
    assign init_done    = (phase == PH_RUN);
    assign refresh_busy = seq_busy;
    assign rfsh_missed  = missed_q;

endmodule

// File: rtl/edo_refresh_sched_chk.sv
`timescale 1ns/1ps
module edo_refresh_sched_chk #(
    parameter int unsigned CLK_MHZ  = 100,
    parameter int unsigned PAUSE_US = 100
) (
    input logic clk,
    input logic rst,
    input logic host_req,
    input logic host_grant,
    input logic ras_n,
    input logic cas_n,
    input logic init_done,
    input logic refresh_busy,
    input logic rfsh_missed
);

    localparam int unsigned PAUSE_CYC = CLK_MHZ * PAUSE_US;

    logic [31:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                    since_rst <= '0;
        else if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1'b1;
    end

    assert_pause_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst < PAUSE_CYC) |-> (ras_n && cas_n));

    assert_cas_leads_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    assert_joint_release_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> $rose(cas_n));

    assert_grant_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(host_grant && refresh_busy));

    assert_grant_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (host_grant && host_req) |=> host_grant);

    assert_grant_after_init_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(host_grant) |-> init_done);

    assert_miss_drops_ready_R8: assert property (@(posedge clk) disable iff (rst)
        rfsh_missed |-> !init_done);

endmodule

bind edo_refresh_sched edo_refresh_sched_chk #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US)) chk_i (
    .clk(clk), .rst(rst), .host_req(host_req), .host_grant(host_grant),
    .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done),
    .refresh_busy(refresh_busy), .rfsh_missed(rfsh_missed)
);

// File: tb/edo_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module edo_refresh_sched_tb_top;

    localparam int CLK_MHZ  = 4;
    localparam int PAUSE_US = 100;
    localparam int CSR_CYC  = 2;
    localparam int RAS_CYC  = 4;
    localparam int PRE_CYC  = 3;
    localparam int MAX_BL   = 3;
    localparam int PAUSE    = CLK_MHZ * PAUSE_US;
    localparam int INTV4    = (CLK_MHZ * 3125) / 100;
    localparam int INTV2    = (CLK_MHZ * 3125) / 50;

    typedef struct { string req; int exp; } item_t;

    logic clk = 1'b0, rst = 1'b1, mode_4k = 1'b1, host_req = 1'b0;
    logic host_grant, ras_n, cas_n, we_n, oe_n, init_done, refresh_busy, rfsh_missed;

    int vecs = 0, fails = 0;
    item_t exp_q[$];
    event ras_fell_ev;
    bit finished = 0;

    always #2 clk = ~clk;

    edo_refresh_sched #(
        .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .CSR_CYC(CSR_CYC),
        .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC), .MAX_BACKLOG(MAX_BL)
    ) dut_i (
        .clk(clk), .rst(rst), .mode_4k(mode_4k), .host_req(host_req),
        .host_grant(host_grant), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .init_done(init_done), .refresh_busy(refresh_busy),
        .rfsh_missed(rfsh_missed)
    );

    task automatic chk(string req, int act, int exp, string what);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_gaps(string req, int n, int gap);
        for (int i = 0; i < n; i++) exp_q.push_back('{req: req, exp: gap});
    endtask

    // Monitor: measures strobe shapes and pops expected refresh spacing.
    int cyc = 0, first_low = 0, ras_falls = 0, last_fall = 0;
    int cas_low_run = 0, ras_low_run = 0, high_run = 0;
    bit ras_prev = 1, cas_prev = 1, init_seen = 0, grant_early = 0, missed_seen = 0;
    bit overlap = 0;

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; first_low = 0; ras_falls = 0; cas_low_run = 0;
            ras_low_run = 0; high_run = 0; ras_prev = 1; cas_prev = 1;
        end else begin
            cyc++;
            if ((!ras_n || !cas_n) && first_low == 0) first_low = cyc;
            if (host_grant && !init_seen) grant_early = 1;
            if (init_done) init_seen = 1;
            if (rfsh_missed) missed_seen = 1;
            if (host_grant && refresh_busy) overlap = 1;
            if (cas_prev && !cas_n && ras_falls > 0)
                chk("R4", (high_run >= PRE_CYC) ? 1 : 0, 1, "precharge at least PRE_CYC");
            if (ras_prev && !ras_n) begin
                ras_falls++;
                chk("R4", cas_low_run, CSR_CYC, "CAS lead before RAS fall");
                chk("R4", {30'd0, we_n, oe_n}, 3, "WE/OE high during refresh");
                if (exp_q.size() > 0) begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(it.req, cyc - last_fall, it.exp, "refresh spacing");
                end
                last_fall = cyc;
                -> ras_fell_ev;
            end
            if (!ras_prev && ras_n) begin
                chk("R4", ras_low_run, RAS_CYC, "RAS active width");
                chk("R4", cas_n, 1, "CAS released with RAS");
            end
            cas_low_run = cas_n ? 0 : cas_low_run + 1;
            ras_low_run = ras_n ? 0 : ras_low_run + 1;
            high_run    = (ras_n && cas_n) ? high_run + 1 : 0;
            ras_prev = ras_n;
            cas_prev = cas_n;
        end
    end

    task automatic wait_grant(int limit);
        for (int i = 0; i < limit && !host_grant; i++) @(negedge clk);
    endtask

    initial begin
        int base;
        host_req = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1", {28'd0, ras_n, cas_n, we_n, oe_n}, 15, "strobes idle in reset");
        chk("R1", {28'd0, init_done, host_grant, refresh_busy, rfsh_missed}, 0, "flags low in reset");
        rst = 1'b0;

        @(posedge init_done);
        @(negedge clk);
        chk("R2", (first_low >= PAUSE && first_low <= PAUSE + 2) ? 1 : 0, 1, "pause length window");
        chk("R3", ras_falls, 8, "wake-up burst count");
        chk("R3", grant_early, 0, "no grant before init_done");
        wait_grant(5);
        chk("R6", host_grant, 1, "grant after init");
        host_req = 1'b0;
        @(negedge clk);
        chk("R6", host_grant, 0, "grant drops after request");

        // R5 4K spacing
        @(ras_fell_ev);
        push_gaps("R5", 3, INTV4);
        while (exp_q.size() > 0) @(negedge clk);
        // R5 2K spacing
        mode_4k = 1'b0;
        repeat (2) @(ras_fell_ev);
        push_gaps("R5", 3, INTV2);
        while (exp_q.size() > 0) @(negedge clk);
        mode_4k = 1'b1;
        repeat (2) @(ras_fell_ev);
        push_gaps("R5", 2, INTV4);
        while (exp_q.size() > 0) @(negedge clk);

        // R7 owed refresh beats a new request
        @(ras_fell_ev);
        while (refresh_busy) @(negedge clk);
        host_req = 1'b1;
        wait_grant(5);
        chk("R6", host_grant, 1, "idle bus granted");
        base = ras_falls;
        repeat (INTV4 + INTV4 / 2) @(negedge clk);
        chk("R6", ras_falls - base, 0, "no refresh during grant");
        host_req = 1'b0;
        @(negedge clk);
        host_req = 1'b1;
        wait_grant(200);
        chk("R7", ras_falls - base, 1, "owed refresh before regrant");
        chk("R7", host_grant, 1, "regrant after refresh");
        host_req = 1'b0;
        @(negedge clk);

        // R8 starvation re-runs the wake-up burst
        while (refresh_busy || !init_done) @(negedge clk);
        missed_seen = 0;
        host_req = 1'b1;
        wait_grant(20);
        base = ras_falls;
        repeat (5 * INTV4) @(negedge clk);
        chk("R8", missed_seen, 1, "miss flagged after backlog overflow");
        chk("R8", init_done, 0, "ready dropped");
        chk("R6", ras_falls - base, 0, "grant kept while starving");
        host_req = 1'b0;
        base = ras_falls;
        @(posedge init_done);
        @(negedge clk);
        chk("R8", ras_falls - base, 8, "repeated wake-up burst count");
        chk("R6", overlap, 0, "grant and refresh never together");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vecs++;
            fails++;
            $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule